// File: doc/BRIEF.md
# Segment Address Translator with Privilege and Rights Checking

This block turns a segment/offset pair into a 32-bit linear address. In the 16-bit compatibility mode the segment value is scaled by sixteen and added to a 16-bit offset, which gives a 1 MB space. In the protected mode the 16-bit segment input is read as a selector. The selector picks a descriptor from one of two small on-chip tables: a shared global table or a per-task local table. The descriptor supplies a base, a limit, a presence bit, a privilege level and type flags. The block adds the base to a 32-bit offset and checks privilege, access type and limit before it declares the address usable.

Software-side logic fills the two tables through a simple write port. A requester raises a strobe for one cycle with the mode, selector, offset, access kind and current privilege level. One cycle later the block pulses a done flag with the linear address, an ok flag and a fault code. When faults coincide, one fixed priority decides which code is reported.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_done`, `rsp_ok`, `rsp_fault` and `rsp_lin` are all zero, and every descriptor in both tables reads as not present.
- R2: `rsp_done` is high in exactly the cycle after each cycle in which `req_valid` is high. All response outputs keep their values while no request is strobed.
- R3: With `req_prot`=0 the result is ok with `rsp_lin` = `req_sel`*16 + `req_offset[15:0]`. If `req_offset` exceeds 0xFFFF the request instead reports the limit fault (code 5).
- R4: The selector is decoded as follows: bits [15:3] are the table index, bit 2 picks the local table when 1 and the global table when 0, and bits [1:0] are the requested privilege level. The table entry is addressed by the low log2(TBL_DEPTH) index bits.
- R5: A protected request with no fault returns `rsp_ok`=1 and `rsp_lin` = base + offset, taken modulo 2^32.
- R6: A descriptor whose present bit is clear gives fault code 1.
- R7: A selector index of TBL_DEPTH or more gives fault code 2.
- R8: The effective level is the larger of `req_cpl` and the requested level. A descriptor level smaller than the effective level gives fault code 3.
- R9: The access encodings are fetch=0, read=1, write=2 and reserved=3. A code descriptor allows fetch, allows read only when its rw flag is set, and never allows write. A data descriptor allows read, allows write only when its rw flag is set, and never allows fetch. Reserved is always refused. A refusal gives fault code 4.
- R10: A protected offset greater than the descriptor limit gives fault code 5.
- R11: When several faults apply, the lowest nonzero code is reported. Any fault forces `rsp_ok`=0 and `rsp_lin`=0.
- R12: A table write (`tbl_local` picks the table) is visible to requests from the next cycle on. A request in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_local | input | 1 | Write target: 1 local table, 0 global table |
| tbl_waddr | input | log2(TBL_DEPTH) | Entry written |
| tbl_base | input | 32 | Descriptor base |
| tbl_limit | input | 32 | Descriptor limit (largest legal offset) |
| tbl_present | input | 1 | Descriptor present bit |
| tbl_dpl | input | 2 | Descriptor privilege level |
| tbl_code | input | 1 | 1 code descriptor, 0 data descriptor |
| tbl_rw | input | 1 | Readable (code) or writable (data) flag |
| req_valid | input | 1 | Request strobe |
| req_prot | input | 1 | 1 protected mode, 0 compatibility mode |
| req_sel | input | 16 | Selector or segment value |
| req_offset | input | 32 | Offset |
| req_acc | input | 2 | Access kind |
| req_cpl | input | 2 | Current privilege level |
| rsp_done | output | 1 | Result strobe, one cycle after request |
| rsp_ok | output | 1 | Address usable |
| rsp_lin | output | 32 | Linear address (zero on fault) |
| rsp_fault | output | 3 | Fault code, 0 when none |

## Verification
The bench builds the block with TBL_DEPTH=4 instead of the default 8. Selector indices 4 and 5 then fold onto loaded and unloaded entries. This shows that an absent descriptor outranks an out-of-range index, and that the index check still fires when the folded entry is present. The small depth also lets a few loads touch both tables, so a local-table write can be shown not to land in the global table.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int PL_W   = 2;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_INDEX  = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_TYPE   = 3'd4,
        FLT_LIMIT  = 3'd5
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              present;
        logic [PL_W-1:0]   dpl;
        logic              is_code;
        logic              rw;
    } desc_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             use_local;
        logic [PL_W-1:0]  rpl;
    } sel_t;

    function automatic logic [PL_W-1:0] pl_max(input logic [PL_W-1:0] a,
                                               input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic kind_allowed(input desc_t d, input acc_e k);
        logic ok;
        unique case (k)
            ACC_FETCH: ok = d.is_code;
            ACC_READ:  ok = d.is_code ? d.rw : 1'b1;
            ACC_WRITE: ok = d.is_code ? 1'b0 : d.rw;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  desc_t         wdata,
    input  logic [AW-1:0] raddr,
    output desc_t         rdata
);

    desc_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R12: a write is in the entry on the following cycle
    a_r12_load_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/seg_real_map.sv
module seg_real_map
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]  seg,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] lin,
    output fault_e            fault
);

    localparam int SPAN_W = SEL_W + 4;

    logic [SPAN_W-1:0] scaled;

    always_comb begin
        scaled = {seg, 4'b0000};
        lin    = ADDR_W'(scaled) + ADDR_W'(offset[SEL_W-1:0]);
        fault  = (offset[ADDR_W-1:SEL_W] != '0) ? FLT_LIMIT : FLT_NONE;
    end

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_pkg::*;
(
    input  desc_t             desc,
    input  logic              idx_in_range,
    input  logic [PL_W-1:0]   rpl,
    input  logic [PL_W-1:0]   cpl,
    input  acc_e              kind,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] lin,
    output fault_e            fault
);

    logic [PL_W-1:0] eff_pl;
    logic            priv_bad;
    logic            kind_bad;
    logic            limit_bad;

    always_comb begin
        eff_pl    = pl_max(cpl, rpl);
        priv_bad  = desc.dpl < eff_pl;
        kind_bad  = !kind_allowed(desc, kind);
        limit_bad = offset > desc.limit;
        lin       = desc.base + offset;

        if (!desc.present)      fault = FLT_ABSENT;
        else if (!idx_in_range) fault = FLT_INDEX;
        else if (priv_bad)      fault = FLT_PRIV;
        else if (kind_bad)      fault = FLT_TYPE;
        else if (limit_bad)     fault = FLT_LIMIT;
        else                    fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int TBL_DEPTH = 8,
    localparam int AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic              tbl_local,
    input  logic [AW-1:0]     tbl_waddr,
    input  logic [31:0]       tbl_base,
    input  logic [31:0]       tbl_limit,
    input  logic              tbl_present,
    input  logic [1:0]        tbl_dpl,
    input  logic              tbl_code,
    input  logic              tbl_rw,
    input  logic              req_valid,
    input  logic              req_prot,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_offset,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_cpl,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic [31:0]       rsp_lin,
    output logic [2:0]        rsp_fault
);

    localparam int NUM_TBL = 2;

    sel_t  sel;
    desc_t wdesc;
    desc_t rd [NUM_TBL];
    desc_t picked;
    logic  idx_in_range;

    assign sel   = sel_t'(req_sel);
    assign wdesc = '{base: tbl_base, limit: tbl_limit, present: tbl_present,
                     dpl: tbl_dpl, is_code: tbl_code, rw: tbl_rw};

    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        seg_desc_table #(.DEPTH(TBL_DEPTH)) i_tbl (
            .clk   (clk),
            .rst   (rst),
            .we    (tbl_we && (tbl_local == (g == 1))),
            .waddr (tbl_waddr),
            .wdata (wdesc),
            .raddr (sel.index[AW-1:0]),
            .rdata (rd[g])
        );
    end

    assign picked       = sel.use_local ? rd[1] : rd[0];
    assign idx_in_range = {19'b0, sel.index} < 32'(TBL_DEPTH);

    logic [31:0] prot_lin;
    fault_e      prot_fault;
    logic [31:0] real_lin;
    fault_e      real_fault;

    seg_rights_check i_chk (
        .desc         (picked),
        .idx_in_range (idx_in_range),
        .rpl          (sel.rpl),
        .cpl          (req_cpl),
        .kind         (acc_e'(req_acc)),
        .offset       (req_offset),
        .lin          (prot_lin),
        .fault        (prot_fault)
    );

    seg_real_map i_real (
        .seg    (req_sel),
        .offset (req_offset),
        .lin    (real_lin),
        .fault  (real_fault)
    );

    fault_e      nxt_fault;
    logic [31:0] nxt_lin;

    always_comb begin
        nxt_fault = req_prot ? prot_fault : real_fault;
        nxt_lin   = (nxt_fault == FLT_NONE) ? (req_prot ? prot_lin : real_lin) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_lin   <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_ok    <= (nxt_fault == FLT_NONE);
                rsp_lin   <= nxt_lin;
                rsp_fault <= nxt_fault;
            end
        end
    end

    // R2: the done pulse follows each strobe by one cycle
    a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_done && $stable(rsp_fault) && $stable(rsp_lin)));

    // R3: compatibility-mode address within a 64 KB offset
    a_r3_real_sum: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_prot && req_offset[31:16] == 16'h0) |=>
            (rsp_ok && rsp_lin == (({16'h0, $past(req_sel)} << 4) + {16'h0, $past(req_offset[15:0])})));

    // R8: top privilege everywhere never yields a privilege fault
    a_r8_full_priv: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prot && req_cpl == 2'd0 && req_sel[1:0] == 2'd0) |=>
            (rsp_fault != 3'(FLT_PRIV)));

    // R11: a fault keeps ok low and the address cleared
    a_r11_fault_clears: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ((rsp_fault != 3'd0) ? (!rsp_ok && rsp_lin == 32'h0) : rsp_ok));

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

    localparam int DEPTH = 4;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_we = 1'b0, tbl_local = 1'b0;
    logic [AW-1:0] tbl_waddr = '0;
    logic [31:0]   tbl_base = '0, tbl_limit = '0;
    logic          tbl_present = 1'b0, tbl_code = 1'b0, tbl_rw = 1'b0;
    logic [1:0]    tbl_dpl = '0;
    logic          req_valid = 1'b0, req_prot = 1'b0;
    logic [15:0]   req_sel = '0;
    logic [31:0]   req_offset = '0;
    logic [1:0]    req_acc = '0, req_cpl = '0;
    logic          rsp_done, rsp_ok;
    logic [31:0]   rsp_lin;
    logic [2:0]    rsp_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seg_xlate #(.TBL_DEPTH(DEPTH)) i_seg_xlate (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input bit loc, input int idx, input logic [31:0] base,
                        input logic [31:0] lim, input bit pres, input logic [1:0] dpl,
                        input bit code, input bit rw);
        @(negedge clk);
        tbl_we = 1'b1; tbl_local = loc; tbl_waddr = AW'(idx);
        tbl_base = base; tbl_limit = lim; tbl_present = pres;
        tbl_dpl = dpl; tbl_code = code; tbl_rw = rw;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic req(input bit prot, input logic [15:0] sel, input logic [31:0] off,
                       input logic [1:0] acc, input logic [1:0] cpl);
        @(negedge clk);
        req_valid = 1'b1; req_prot = prot; req_sel = sel;
        req_offset = off; req_acc = acc; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [2:0] flt, input logic [31:0] lin);
        check({tag, " done"}, 32'(rsp_done), 32'd1);
        check({tag, " fault"}, 32'(rsp_fault), 32'(flt));
        check({tag, " ok"}, 32'(rsp_ok), (flt == 3'd0) ? 32'd1 : 32'd0);
        check({tag, " lin"}, rsp_lin, lin);
    endtask

    task automatic t_reset;
        check("R1 done", 32'(rsp_done), 0);
        check("R1 ok", 32'(rsp_ok), 0);
        check("R1 fault", 32'(rsp_fault), 0);
        check("R1 lin", rsp_lin, 0);
        req(1, 16'h0000, 0, 2'd1, 2'd0);
        expect_rsp("R1 empty global", 3'd1, 0);
        req(1, 16'h0004, 0, 2'd1, 2'd0);
        expect_rsp("R1 empty local", 3'd1, 0);
    endtask

    task automatic t_timing;
        req(0, 16'h0001, 32'h2, 2'd1, 2'd0);
        @(negedge clk);
        check("R2 done drops", 32'(rsp_done), 0);
        check("R2 lin holds", rsp_lin, 32'h12);
        check("R2 ok holds", 32'(rsp_ok), 1);
    endtask

    task automatic t_real;
        req(0, 16'h1234, 32'h0010, 2'd2, 2'd3);
        expect_rsp("R3 plain", 3'd0, 32'h0001_2350);
        req(0, 16'hFFFF, 32'h0000_FFFF, 2'd0, 2'd3);
        expect_rsp("R3 top", 3'd0, 32'h0010_FFEF);
        req(0, 16'h0100, 32'h0001_0000, 2'd1, 2'd3);
        expect_rsp("R3 over 64K", 3'd5, 0);
    endtask

    task automatic t_load;
        load(0, 0, 32'h1000_0000, 32'h0000_FFFF, 1, 2'd3, 0, 1);
        load(1, 1, 32'h2000_0000, 32'h0000_00FF, 1, 2'd0, 1, 0);
        load(0, 2, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1, 2'd1, 0, 0);
    endtask

    task automatic t_prot_ok;
        req(1, 16'h0003, 32'h1234, 2'd1, 2'd3);
        expect_rsp("R5 read", 3'd0, 32'h1000_1234);
        req(1, 16'h0003, 32'h0040, 2'd2, 2'd3);
        expect_rsp("R5 write", 3'd0, 32'h1000_0040);
        req(1, 16'h0011, 32'h0020, 2'd1, 2'd1);
        expect_rsp("R5 wrap", 3'd0, 32'h0000_0010);
    endtask

    task automatic t_tables;
        req(1, 16'h000C, 32'h5, 2'd0, 2'd0);
        expect_rsp("R4 local fetch", 3'd0, 32'h2000_0005);
        req(1, 16'h0008, 32'h5, 2'd0, 2'd0);
        expect_rsp("R12 global untouched", 3'd1, 0);
        req(1, 16'h0004, 32'h5, 2'd1, 2'd0);
        expect_rsp("R6 local absent", 3'd1, 0);
    endtask

    task automatic t_index;
        req(1, 16'h0020, 32'h0, 2'd1, 2'd0);
        expect_rsp("R7 index 4", 3'd2, 0);
        req(1, 16'h0028, 32'h0, 2'd1, 2'd0);
        expect_rsp("R11 absent beats index", 3'd1, 0);
    endtask

    task automatic t_priv;
        req(1, 16'h0010, 32'h0, 2'd1, 2'd2);
        expect_rsp("R8 cpl low", 3'd3, 0);
        req(1, 16'h0012, 32'h0, 2'd1, 2'd1);
        expect_rsp("R8 rpl low", 3'd3, 0);
        req(1, 16'h0011, 32'h0, 2'd1, 2'd0);
        expect_rsp("R8 rpl equal", 3'd0, 32'hFFFF_FFF0);
    endtask

    task automatic t_type;
        req(1, 16'h000C, 32'h0, 2'd1, 2'd0);
        expect_rsp("R9 code read", 3'd4, 0);
        req(1, 16'h000C, 32'h0, 2'd2, 2'd0);
        expect_rsp("R9 code write", 3'd4, 0);
        req(1, 16'h0000, 32'h0, 2'd0, 2'd0);
        expect_rsp("R9 data fetch", 3'd4, 0);
        req(1, 16'h0010, 32'h0, 2'd2, 2'd0);
        expect_rsp("R9 data ro write", 3'd4, 0);
        req(1, 16'h0000, 32'h0, 2'd3, 2'd0);
        expect_rsp("R9 reserved", 3'd4, 0);
        load(1, 2, 32'h3000_0000, 32'hFF, 1, 2'd3, 1, 1);
        req(1, 16'h0014, 32'h8, 2'd1, 2'd3);
        expect_rsp("R9 code readable", 3'd0, 32'h3000_0008);
    endtask

    task automatic t_limit;
        req(1, 16'h0000, 32'h0000_FFFF, 2'd1, 2'd0);
        expect_rsp("R10 at limit", 3'd0, 32'h1000_FFFF);
        req(1, 16'h0000, 32'h0001_0000, 2'd1, 2'd0);
        expect_rsp("R10 past limit", 3'd5, 0);
        req(1, 16'h000C, 32'h0000_0100, 2'd0, 2'd0);
        expect_rsp("R10 code past", 3'd5, 0);
    endtask

    task automatic t_priority;
        req(1, 16'h000C, 32'h0000_0100, 2'd2, 2'd3);
        expect_rsp("R11 priv first", 3'd3, 0);
        req(1, 16'h000C, 32'h0000_0200, 2'd2, 2'd0);
        expect_rsp("R11 type before limit", 3'd4, 0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        tbl_we = 1'b1; tbl_local = 1'b0; tbl_waddr = AW'(3);
        tbl_base = 32'h4000_0000; tbl_limit = 32'hFFFF; tbl_present = 1'b1;
        tbl_dpl = 2'd3; tbl_code = 1'b0; tbl_rw = 1'b1;
        req_valid = 1'b1; req_prot = 1'b1; req_sel = 16'h0018;
        req_offset = 32'h4; req_acc = 2'd1; req_cpl = 2'd3;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        expect_rsp("R12 same cycle old", 3'd1, 0);
        req(1, 16'h0018, 32'h4, 2'd1, 2'd3);
        expect_rsp("R12 next cycle new", 3'd0, 32'h4000_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_real;
        t_timing;
        t_load;
        t_prot_ok;
        t_tables;
        t_index;
        t_priv;
        t_type;
        t_limit;
        t_priority;
        t_same_cycle;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule